// File: doc/BRIEF.md
# Dual-Panel Frame Buffer Address Generator

This block produces the memory fetch addresses for a display controller that drives either one full panel or two half-panels. It has two address channels. The upper channel covers the whole screen in single-panel mode, or the top half in dual-panel mode. The lower channel serves only the bottom half, and only when dual-panel mode is selected. Only the upper channel's buffer begins with a colour palette, which is 16 or 256 entries of two bytes each. The lower channel's base points straight at encoded pixel data.

Software uses a small register bus to program the following:
- a control word: enable, and dual-panel select;
- one base address for each channel.

Each channel keeps a read-only current pointer and a frame start. Both are copied from the base when the display is enabled, and again each time the channel finishes its buffer. A base-update flag, with its interrupt line, tells software that a base has just been consumed and may now be replaced with the next buffer.

A sequencer has three states:
- **OFF**: no fetches are requested.
- **LOAD**: a single cycle in which both channels copy their bases and the flag is set.
- **RUN**: fetches are requested.

The transitions are:
- **OFF→LOAD** when the enable bit reads 1.
- **LOAD→RUN** when enable is still 1.
- **LOAD→OFF** when enable has dropped.
- **RUN→OFF** when enable is cleared.

Top module: `fb_addr_gen`

## Requirements
- R1: After reset, the following are all zero: the control word, both bases, both current pointers and the flag. No fetch is requested and `irq` is low.
- R2: A base write stores the data with bits 3:0 forced to zero. A base write takes effect only while enable is 0 or the flag is 1, and is ignored otherwise.
- R3: The control word has enable at bit 0 and dual select at bit 1. Enable is always writable. The dual bit takes the written value only if enable was 0 before that write.
- R4: Software writes enable from 0 to 1. Two clock edges after the write edge, each current pointer equals its base, the flag is set, and requests begin.
- R5: `fetch_req[0]` is high in RUN. `fetch_req[1]` is high only in RUN with dual select at 1. A grant to a channel that is not requesting changes nothing.
- R6: Each granted fetch on a requesting channel advances that channel's current pointer by 16. A request that is not granted leaves the pointer unchanged.
- R7: The upper channel's end address is its frame start plus `frame_bytes` plus the palette length. The palette length is 32 bytes, or 512 bytes when `pal_large` is 1. When an advance would reach the end address, the current pointer and frame start reload from the base register and the flag is set.
- R8: The lower channel's end address is its frame start plus `frame_bytes`, with no palette. It reloads and sets the flag in the same way as the upper channel.
- R9: Writing status with bit 0 at 1 clears the flag. A flag set in the same cycle wins over the clear. `irq` equals the flag.
- R10: When enable is written to 0, requests drop immediately after that write edge. While disabled, both current pointers hold their values.
- R11: Register reads are combinational on `reg_sel`, with this map:

| `reg_sel` | Register |
|---|---|
| 0 | control |
| 1 | upper base |
| 2 | lower base |
| 3 | upper current |
| 4 | lower current |
| 5 | status (flag at bit 0) |
| other | reads 0 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| frame_bytes | input | 24 | Pixel bytes per channel buffer, a multiple of 16 |
| pal_large | input | 1 | Palette is 256 entries (1) or 16 entries (0) |
| fetch_req | output | 2 | Fetch request: bit 0 upper, bit 1 lower |
| fetch_gnt | input | 2 | Fetch grant, one bit per channel |
| up_addr | output | 32 | Upper channel fetch address |
| lo_addr | output | 32 | Lower channel fetch address |
| irq | output | 1 | Base-update interrupt |

## Verification
The assertions check several rules on every cycle:
- pointer alignment;
- the lower channel requesting only in dual mode;
- no requests while disabled;
- a grant advancing the pointer by 16 unless a reload set the flag;
- a pointer holding when there is no grant;
- the flag persisting until a clear is written.

Only the bench scenarios can show the rest:
- the exact reload addresses at the end of a buffer, including the palette offset for both palette sizes;
- base writes being accepted or ignored depending on enable and the flag;
- the dual bit locking while enabled;
- the double-buffer sequence, in which a base written after a wrap is picked up only at the next wrap.

// File: rtl/fbag_pkg.sv
package fbag_pkg;

    typedef enum logic [1:0] {
        SEQ_OFF,
        SEQ_LOAD,
        SEQ_RUN
    } seq_state_e;

    localparam logic [2:0] SEL_CTRL    = 3'd0;
    localparam logic [2:0] SEL_BASE_UP = 3'd1;
    localparam logic [2:0] SEL_BASE_LO = 3'd2;
    localparam logic [2:0] SEL_CUR_UP  = 3'd3;
    localparam logic [2:0] SEL_CUR_LO  = 3'd4;
    localparam logic [2:0] SEL_STATUS  = 3'd5;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_DUAL_BIT = 1;
    localparam int STAT_FLAG_BIT = 0;

endpackage

// File: rtl/fbag_seq.sv
module fbag_seq
    import fbag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic load,
    output logic run
);

    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        run     = 1'b0;
        unique case (state_q)
            SEQ_OFF: begin
                if (en) state_d = SEQ_LOAD;
            end
            SEQ_LOAD: begin
                load    = 1'b1;
                state_d = en ? SEQ_RUN : SEQ_OFF;
            end
            SEQ_RUN: begin
                run = en;
                if (!en) state_d = SEQ_OFF;
            end
            default: state_d = SEQ_OFF;
        endcase
    end

endmodule

// File: rtl/fbag_chan.sv
module fbag_chan #(
    parameter int AW         = 32,
    parameter int SZW        = 24,
    parameter int ALIGN_BITS = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           adv,
    input  logic [AW-1:0]  base,
    input  logic [SZW-1:0] size,
    output logic [AW-1:0]  cur,
    output logic           wrap
);

    localparam int STEP = 1 << ALIGN_BITS;

    logic [AW-1:0] start_q;
    logic [AW-1:0] end_addr;
    logic [AW-1:0] next_addr;

    assign end_addr  = start_q + AW'(size);
    assign next_addr = cur + AW'(STEP);
    assign wrap      = adv && (next_addr == end_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur     <= '0;
            start_q <= '0;
        end else if (load || wrap) begin
            cur     <= base;
            start_q <= base;
        end else if (adv) begin
            cur     <= next_addr;
        end
    end

endmodule

// File: rtl/fbag_regs.sv
module fbag_regs
    import fbag_pkg::*;
#(
    parameter int AW         = 32,
    parameter int ALIGN_BITS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [2:0]    sel,
    input  logic [AW-1:0] wdata,
    input  logic [AW-1:0] cur_up,
    input  logic [AW-1:0] cur_lo,
    input  logic          set_flag,
    output logic          en,
    output logic          dual,
    output logic [AW-1:0] base_up,
    output logic [AW-1:0] base_lo,
    output logic          flag,
    output logic [AW-1:0] rdata
);

    logic          base_ok;
    logic          clr_flag;
    logic [AW-1:0] wbase;

    assign base_ok  = !en || flag;
    assign clr_flag = we && (sel == SEL_STATUS) && wdata[STAT_FLAG_BIT];
    assign wbase    = {wdata[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en      <= 1'b0;
            dual    <= 1'b0;
            base_up <= '0;
            base_lo <= '0;
        end else if (we) begin
            if (sel == SEL_CTRL) begin
                en <= wdata[CTRL_EN_BIT];
                if (!en) dual <= wdata[CTRL_DUAL_BIT];
            end
            if (sel == SEL_BASE_UP && base_ok) base_up <= wbase;
            if (sel == SEL_BASE_LO && base_ok) base_lo <= wbase;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_flag) begin
            flag <= 1'b1;
        end else if (clr_flag) begin
            flag <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CTRL: begin
                rdata[CTRL_EN_BIT]   = en;
                rdata[CTRL_DUAL_BIT] = dual;
            end
            SEL_BASE_UP: rdata = base_up;
            SEL_BASE_LO: rdata = base_lo;
            SEL_CUR_UP:  rdata = cur_up;
            SEL_CUR_LO:  rdata = cur_lo;
            SEL_STATUS:  rdata[STAT_FLAG_BIT] = flag;
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/fb_addr_gen.sv
module fb_addr_gen
    import fbag_pkg::*;
#(
    parameter int AW                = 32,
    parameter int SZW               = 24,
    parameter int ALIGN_BITS        = 4,
    parameter int PAL_ENTRY_BYTES   = 2,
    parameter int PAL_SMALL_ENTRIES = 16,
    parameter int PAL_LARGE_ENTRIES = 256
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [2:0]     reg_sel,
    input  logic [AW-1:0]  reg_wdata,
    output logic [AW-1:0]  reg_rdata,
    input  logic [SZW-1:0] frame_bytes,
    input  logic           pal_large,
    output logic [1:0]     fetch_req,
    input  logic [1:0]     fetch_gnt,
    output logic [AW-1:0]  up_addr,
    output logic [AW-1:0]  lo_addr,
    output logic           irq
);

    localparam int NCH             = 2;
    localparam int PAL_SMALL_BYTES = PAL_SMALL_ENTRIES * PAL_ENTRY_BYTES;
    localparam int PAL_LARGE_BYTES = PAL_LARGE_ENTRIES * PAL_ENTRY_BYTES;

    logic          ctl_en;
    logic          ctl_dual;
    logic          flag;
    logic          seq_load;
    logic          seq_run;
    logic [AW-1:0] base_up;
    logic [AW-1:0] base_lo;
    logic [AW-1:0] base_arr [NCH];
    logic [AW-1:0] cur_arr  [NCH];
    logic [NCH-1:0] wrap_vec;
    logic [SZW-1:0] pal_bytes;

    assign pal_bytes   = pal_large ? SZW'(PAL_LARGE_BYTES) : SZW'(PAL_SMALL_BYTES);
    assign base_arr[0] = base_up;
    assign base_arr[1] = base_lo;

    assign fetch_req[0] = seq_run;
    assign fetch_req[1] = seq_run && ctl_dual;
    assign up_addr      = cur_arr[0];
    assign lo_addr      = cur_arr[1];
    assign irq          = flag;

    fbag_regs #(
        .AW         (AW),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .cur_up   (cur_arr[0]),
        .cur_lo   (cur_arr[1]),
        .set_flag (seq_load || (|wrap_vec)),
        .en       (ctl_en),
        .dual     (ctl_dual),
        .base_up  (base_up),
        .base_lo  (base_lo),
        .flag     (flag),
        .rdata    (reg_rdata)
    );

    fbag_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctl_en),
        .load  (seq_load),
        .run   (seq_run)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
        logic [SZW-1:0] chan_size;
        if (gi == 0) begin : g_pal
            assign chan_size = frame_bytes + pal_bytes;
        end else begin : g_nopal
            assign chan_size = frame_bytes;
        end

        fbag_chan #(
            .AW         (AW),
            .SZW        (SZW),
            .ALIGN_BITS (ALIGN_BITS)
        ) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (seq_load),
            .adv   (fetch_req[gi] && fetch_gnt[gi]),
            .base  (base_arr[gi]),
            .size  (chan_size),
            .cur   (cur_arr[gi]),
            .wrap  (wrap_vec[gi])
        );
    end

endmodule

// File: rtl/fbag_checker.sv
module fbag_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [2:0]    reg_sel,
    input logic [AW-1:0] reg_wdata,
    input logic [1:0]    fetch_req,
    input logic [1:0]    fetch_gnt,
    input logic [AW-1:0] up_addr,
    input logic [AW-1:0] lo_addr,
    input logic          irq,
    input logic          en,
    input logic          dual
);

    assert_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (up_addr[3:0] == 4'd0) && (lo_addr[3:0] == 4'd0));

    assert_lo_dual_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req[1] |-> dual);

    assert_req_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req != 2'b00) |-> en);

    assert_up_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req[0] && fetch_gnt[0]) |=> ((up_addr == $past(up_addr) + 32'd16) || irq));

    assert_lo_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req[1] && fetch_gnt[1]) |=> ((lo_addr == $past(lo_addr) + 32'd16) || irq));

    assert_up_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req[0] && !fetch_gnt[0]) |=> $stable(up_addr));

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_we && reg_sel == 3'd5 && reg_wdata[0])) |=> irq);

endmodule

bind fb_addr_gen fbag_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .fetch_req (fetch_req),
    .fetch_gnt (fetch_gnt),
    .up_addr   (up_addr),
    .lo_addr   (lo_addr),
    .irq       (irq),
    .en        (ctl_en),
    .dual      (ctl_dual)
);

// File: tb/sim_fb_addr_gen.sv
module sim_fb_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [2:0]  reg_sel;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [23:0] frame_bytes;
    logic        pal_large;
    logic [1:0]  fetch_req;
    logic [1:0]  fetch_gnt;
    logic [31:0] up_addr;
    logic [31:0] lo_addr;
    logic        irq;

    always #10 clk = ~clk;

    fb_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_bytes(frame_bytes),
        .pal_large(pal_large), .fetch_req(fetch_req), .fetch_gnt(fetch_gnt),
        .up_addr(up_addr), .lo_addr(lo_addr), .irq(irq)
    );

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        int          ch;
        logic [31:0] addr;
        string       tag;
    } item_t;
    item_t sb[$];

    logic [31:0] m_base  [2];
    logic [31:0] m_cur   [2];
    logic [31:0] m_start [2];
    logic [31:0] m_size  [2];
    bit          m_flag;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(logic [2:0] sel, logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(logic [2:0] sel, output logic [31:0] data);
        @(negedge clk);
        reg_sel = sel;
        #2 data = reg_rdata;
    endtask

    task automatic rd_chk(logic [2:0] sel, logic [31:0] exp, string tag);
        logic [31:0] v;
        reg_read(sel, v);
        chk(tag, v, exp);
    endtask

    task automatic clear_flag();
        reg_write(3'd5, 32'h1);
        m_flag = 1'b0;
    endtask

    // driver: grant one fetch on a channel and push the expected address
    task automatic grant(int ch, string tag);
        logic [31:0] nxt;
        @(negedge clk);
        chk({tag, " req"}, 32'(fetch_req[ch]), 32'd1);
        sb.push_back('{ch, m_cur[ch], tag});
        fetch_gnt[ch] = 1'b1;
        nxt = m_cur[ch] + 32'd16;
        if (nxt == m_start[ch] + m_size[ch]) begin
            m_cur[ch] = m_base[ch]; m_start[ch] = m_base[ch]; m_flag = 1'b1;
        end else begin
            m_cur[ch] = nxt;
        end
        @(negedge clk);
        fetch_gnt[ch] = 1'b0;
    endtask

    // monitor: compare every handshake against the queue
    initial begin
        forever begin
            @(negedge clk);
            #2;
            for (int c = 0; c < 2; c++) begin
                if (fetch_gnt[c] && fetch_req[c]) begin
                    if (sb.size() == 0) begin
                        chk("R6 unexpected fetch", 32'(c), 32'hFFFF_FFFF);
                    end else begin
                        item_t it;
                        it = sb.pop_front();
                        chk({it.tag, " channel"}, 32'(c), 32'(it.ch));
                        chk({it.tag, " address"}, c == 0 ? up_addr : lo_addr, it.addr);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; reg_we = 1'b0; reg_sel = 3'd0; reg_wdata = '0;
        fetch_gnt = 2'b00; frame_bytes = 24'd64; pal_large = 1'b0;
        m_flag = 1'b0;
        m_size[0] = 32'd96; m_size[1] = 32'd64;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R11: reset state through the read map
        for (int s = 0; s < 8; s++) rd_chk(3'(s), 32'h0, "R1 R11 reset read");
        chk("R1 no request", 32'(fetch_req), 32'd0);
        chk("R1 irq low", 32'(irq), 32'd0);

        // R2: alignment on write while disabled
        reg_write(3'd1, 32'h1000_0007);
        reg_write(3'd2, 32'h2000_000F);
        rd_chk(3'd1, 32'h1000_0000, "R2 upper base aligned");
        rd_chk(3'd2, 32'h2000_0000, "R2 lower base aligned");
        m_base[0] = 32'h1000_0000; m_base[1] = 32'h2000_0000;

        // R3: dual select while disabled
        reg_write(3'd0, 32'h2);
        rd_chk(3'd0, 32'h2, "R3 dual set while disabled");

        // R4: enable loads currents and sets flag
        reg_write(3'd0, 32'h3);
        repeat (2) @(negedge clk);
        m_cur[0] = m_base[0]; m_start[0] = m_base[0];
        m_cur[1] = m_base[1]; m_start[1] = m_base[1]; m_flag = 1'b1;
        rd_chk(3'd3, m_base[0], "R4 upper current loaded");
        rd_chk(3'd4, m_base[1], "R4 lower current loaded");
        chk("R4 flag set", 32'(irq), 32'd1);
        chk("R5 both request in dual", 32'(fetch_req), 32'd3);

        // R9: clear
        clear_flag();
        chk("R9 flag cleared", 32'(irq), 32'd0);

        // R2: base write ignored while enabled and flag clear
        reg_write(3'd1, 32'h3000_0000);
        rd_chk(3'd1, m_base[0], "R2 base write ignored");

        // R3: dual locked while enabled
        reg_write(3'd0, 32'h1);
        rd_chk(3'd0, 32'h3, "R3 dual locked");

        // R6 / R7: upper channel, palette 32 + frame 64 = 6 fetches
        for (int i = 0; i < 5; i++) grant(0, "R6 upper step");
        chk("R7 no wrap before end", 32'(irq), 32'd0);
        grant(0, "R7 upper last");
        rd_chk(3'd3, m_base[0], "R7 upper reload");
        chk("R7 flag on wrap", 32'(irq), 32'(m_flag));

        // double buffering: base accepted while flag set, used at next wrap
        reg_write(3'd1, 32'h1800_0000);
        rd_chk(3'd1, 32'h1800_0000, "R2 base accepted with flag");
        m_base[0] = 32'h1800_0000;
        clear_flag();
        for (int i = 0; i < 6; i++) grant(0, "R7 upper second frame");
        rd_chk(3'd3, 32'h1800_0000, "R7 new base at wrap");
        chk("R9 irq follows flag", 32'(irq), 32'd1);

        // R8: lower channel, no palette, 4 fetches
        clear_flag();
        for (int i = 0; i < 4; i++) grant(1, "R8 lower step");
        rd_chk(3'd4, m_base[1], "R8 lower reload");
        chk("R8 flag on wrap", 32'(irq), 32'd1);

        // R10: disable
        reg_write(3'd0, 32'h0);
        chk("R10 requests drop", 32'(fetch_req), 32'd0);
        rd_chk(3'd0, 32'h2, "R3 dual kept on disabling write");
        fetch_gnt = 2'b11;
        repeat (3) @(negedge clk);
        fetch_gnt = 2'b00;
        chk("R10 upper holds", up_addr, m_cur[0]);
        chk("R10 lower holds", lo_addr, m_cur[1]);

        // single panel with large palette: 512 + 64 = 36 fetches
        reg_write(3'd0, 32'h0);
        rd_chk(3'd0, 32'h0, "R3 dual cleared while disabled");
        pal_large = 1'b1;
        m_size[0] = 32'd576;
        clear_flag();
        reg_write(3'd0, 32'h1);
        repeat (2) @(negedge clk);
        m_cur[0] = m_base[0]; m_start[0] = m_base[0];
        m_cur[1] = m_base[1]; m_start[1] = m_base[1]; m_flag = 1'b1;
        chk("R5 only upper in single", 32'(fetch_req), 32'd1);
        chk("R4 reload on second enable", up_addr, m_base[0]);
        fetch_gnt[1] = 1'b1;
        @(negedge clk);
        fetch_gnt[1] = 1'b0;
        @(negedge clk);
        chk("R5 lower grant ignored", lo_addr, m_base[1]);
        clear_flag();
        for (int i = 0; i < 35; i++) grant(0, "R7 large palette step");
        chk("R7 no early wrap large", 32'(irq), 32'd0);
        grant(0, "R7 large palette last");
        chk("R7 large wrap address", up_addr, m_base[0]);
        chk("R7 large wrap flag", 32'(irq), 32'd1);

        repeat (2) @(negedge clk);
        chk("R6 scoreboard drained", 32'(sb.size()), 32'd0);
        finish_run();
    end

endmodule